// File: doc/BRIEF.md
# Vector length configuration unit

This unit executes one vector-length configuration instruction in a 64-bit scalar pipeline stage. When a 32-bit instruction word arrives with its valid strobe, the unit decodes it. It reads one scalar source register through a combinational read port. It works out a new vector length from an 11-bit immediate maximum and the optional register operand. In the same cycle it issues a write of that length to a destination register. It also holds the current vector length in an internal register, which is exposed as an output.

Encodings that carry the reserved top bit, or that ask for a maximum length beyond the scalar width, raise a one-cycle illegal-instruction pulse. Such encodings change nothing. Words belonging to other instructions pass through with no effect. The register file sits outside the block and has 128 entries, so all register indices on the ports are 7 bits wide.

Top module: `vlcfg_unit`

## Requirements
- R1: The word is recognised only when bits [6:0] equal 7'b1010111 and bits [14:12] equal 3'b111. Any other word, or any word without the valid strobe, produces no write and no trap, and leaves the vector length unchanged.
- R2: A recognised word with bit 31 set to 1 is reserved. It raises the trap, issues no write and leaves the vector length unchanged.
- R3: Bits [30:20] form an unsigned maximum. A value greater than 64 traps with no write and no vector-length change. A value of exactly 64 is legal.
- R4: When the source index (bits [19:15]) is zero, the new length equals the immediate maximum.
- R5: When the source index is nonzero, the new length is the unsigned minimum of the 64-bit source value and the immediate maximum.
- R6: When the destination index (bits [11:7]) is nonzero, a legal word writes the new length, zero-extended to 64 bits, to that register. When the destination index is zero, no write is issued, but the vector length still updates.
- R7: The read and write indices on the ports are the 5-bit fields zero-extended to 7 bits.
- R8: The vector-length register takes the new length on the clock edge after a valid, legal word. It resets to 0 under a synchronous active-high reset, and reset takes priority over an instruction in the same cycle.
- R9: The trap output is high only in the cycle in which the valid strobe presents the illegal word. It is the same cycle in which a write would otherwise have been issued.
- R10: The source read is combinational, so the write enable, index and data are valid in the same cycle as the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| insn_valid | input | 1 | Instruction word is present this cycle |
| insn_word | input | 32 | Instruction word |
| src_idx | output | 7 | Source register read index |
| src_data | input | 64 | Source register value, combinational from the read index |
| wr_en | output | 1 | Destination register write enable |
| wr_idx | output | 7 | Destination register write index |
| wr_data | output | 64 | Destination register write data |
| trap_pulse | output | 1 | Illegal-instruction trap |
| cur_vl | output | 7 | Current vector length |

## Verification
The assertions assume three things about the inputs. First, the valid strobe is never X after reset. Second, src_data settles combinationally from src_idx within the same cycle. Third, each instruction is held for exactly one clock edge, so that a trap shows up as a single-cycle event. The bench drives every word on the falling edge and keeps the strobe high across exactly one rising edge. It supplies src_data directly for each vector, as a register file with a zero-latency read would. Words that other units own are presented both with and without the strobe.

// File: rtl/vlcfg_pkg.sv
package vlcfg_pkg;
   localparam int INSN_W  = 32;
   localparam int FIELD_W = 5;
   localparam int IMM_W   = 11;

   localparam logic [6:0] MAJOR_OP = 7'b1010111;
   localparam logic [2:0] MINOR_FN = 3'b111;

   typedef struct packed {
      logic              rsvd;
      logic [IMM_W-1:0]  vlmax;
      logic [FIELD_W-1:0] rs;
      logic [2:0]        fn;
      logic [FIELD_W-1:0] rd;
      logic [6:0]        op;
   } vlcfg_insn_t;
endpackage

// File: rtl/vlcfg_decode.sv
module vlcfg_decode
   import vlcfg_pkg::*;
#(
   parameter int XLEN  = 64,
   parameter int IDX_W = 7
) (
   input  logic                 valid,
   input  logic [INSN_W-1:0]    word,
   output logic                 hit,
   output logic                 illegal,
   output logic [IDX_W-1:0]     rs_idx,
   output logic [IDX_W-1:0]     rd_idx,
   output logic [IMM_W-1:0]     vlmax,
   output logic                 rs_zero,
   output logic                 rd_zero
);
   localparam logic [IMM_W-1:0] LIMIT = IMM_W'(XLEN);

   vlcfg_insn_t f;
   assign f = vlcfg_insn_t'(word);

   generate
      if (IDX_W == FIELD_W) begin : g_idx_same
         assign rs_idx = f.rs;
         assign rd_idx = f.rd;
      end else begin : g_idx_wide
         assign rs_idx = {{(IDX_W-FIELD_W){1'b0}}, f.rs};
         assign rd_idx = {{(IDX_W-FIELD_W){1'b0}}, f.rd};
      end
   endgenerate

   assign vlmax   = f.vlmax;
   assign rs_zero = (f.rs == '0);
   assign rd_zero = (f.rd == '0);
   assign hit     = valid && (f.op == MAJOR_OP) && (f.fn == MINOR_FN);
   assign illegal = hit && (f.rsvd || (f.vlmax > LIMIT));
endmodule

// File: rtl/vlcfg_clamp.sv
module vlcfg_clamp
   import vlcfg_pkg::*;
#(
   parameter int XLEN = 64,
   parameter int VL_W = 7
) (
   input  logic [IMM_W-1:0] vlmax,
   input  logic             rs_zero,
   input  logic [XLEN-1:0]  src,
   output logic [VL_W-1:0]  new_vl
);
   logic             src_big;
   logic [IMM_W-1:0] src_lo;
   logic [IMM_W-1:0] pick;

   assign src_big = (src[XLEN-1:IMM_W] != '0);
   assign src_lo  = src[IMM_W-1:0];

   always_comb begin
      if (rs_zero || src_big || (src_lo >= vlmax)) pick = vlmax;
      else                                         pick = src_lo;
   end

   assign new_vl = pick[VL_W-1:0];
endmodule

// File: rtl/vlcfg_unit.sv
module vlcfg_unit
   import vlcfg_pkg::*;
#(
   parameter int XLEN  = 64,
   parameter int IDX_W = 7
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              insn_valid,
   input  logic [31:0]       insn_word,
   output logic [IDX_W-1:0]  src_idx,
   input  logic [XLEN-1:0]   src_data,
   output logic              wr_en,
   output logic [IDX_W-1:0]  wr_idx,
   output logic [XLEN-1:0]   wr_data,
   output logic              trap_pulse,
   output logic [$clog2(XLEN+1)-1:0] cur_vl
);
   localparam int VL_W = $clog2(XLEN + 1);

   generate
      if (XLEN <= IMM_W || XLEN >= (1 << IMM_W)) begin : g_bad_xlen
         $error("vlcfg_unit: XLEN must lie between IMM_W+1 and 2**IMM_W-1");
      end
      if (IDX_W < FIELD_W) begin : g_bad_idx
         $error("vlcfg_unit: IDX_W narrower than the register field");
      end
   endgenerate

   logic             hit, illegal, rs_zero, rd_zero;
   logic [IMM_W-1:0] vlmax;
   logic [VL_W-1:0]  new_vl;
   logic [VL_W-1:0]  vl_q;
   logic             take;

   vlcfg_decode #(.XLEN(XLEN), .IDX_W(IDX_W)) u_dec (
      .valid   (insn_valid),
      .word    (insn_word),
      .hit     (hit),
      .illegal (illegal),
      .rs_idx  (src_idx),
      .rd_idx  (wr_idx),
      .vlmax   (vlmax),
      .rs_zero (rs_zero),
      .rd_zero (rd_zero)
   );

   vlcfg_clamp #(.XLEN(XLEN), .VL_W(VL_W)) u_clamp (
      .vlmax   (vlmax),
      .rs_zero (rs_zero),
      .src     (src_data),
      .new_vl  (new_vl)
   );

   assign take       = hit && !illegal;
   assign wr_en      = take && !rd_zero;
   assign wr_data    = {{(XLEN-VL_W){1'b0}}, new_vl};
   assign trap_pulse = illegal;
   assign cur_vl     = vl_q;

   always_ff @(posedge clk) begin
      if (rst)       vl_q <= '0;
      else if (take) vl_q <= new_vl;
   end

   // R9: a trap never coexists with a write and needs the strobe
   a_r9_trap_excl: assert property (@(posedge clk) disable iff (rst)
      trap_pulse |-> (insn_valid && !wr_en));
   // R1: no strobe, no effect
   a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
      !insn_valid |-> (!wr_en && !trap_pulse));
   // R2 / R3: illegal words hold the vector length
   a_r3_trap_holds_vl: assert property (@(posedge clk) disable iff (rst)
      trap_pulse |=> (cur_vl == $past(cur_vl)));
   // R8: a write lands in the vector-length register on the next edge
   a_r8_vl_follows_write: assert property (@(posedge clk) disable iff (rst)
      wr_en |=> (cur_vl == $past(wr_data[VL_W-1:0])));
   // R6: writes never go to register zero and stay within XLEN
   a_r6_write_bounds: assert property (@(posedge clk) disable iff (rst)
      wr_en |-> ((wr_idx != '0) && (wr_data <= XLEN)));
   // R8: idle cycles keep the vector length
   a_r8_idle_hold: assert property (@(posedge clk) disable iff (rst)
      !insn_valid |=> $stable(cur_vl));
endmodule

// File: tb/sim_vlcfg_unit.sv
module sim_vlcfg_unit;
   localparam int CLK_PERIOD = 10;
   localparam logic [6:0] OPV = 7'b1010111;
   localparam logic [6:0] OPX = 7'b0110011;

   typedef struct packed {
      logic [31:0] insn;
      logic [63:0] src;
      logic        we;
      logic [6:0]  widx;
      logic [63:0] wdata;
      logic        trap;
      logic [6:0]  vl;
   } vec_t;

   function automatic logic [31:0] enc(input logic b31, input logic [10:0] imm,
      input logic [4:0] rs, input logic [2:0] fn, input logic [4:0] rd, input logic [6:0] op);
      return {b31, imm, rs, fn, rd, op};
   endfunction

   localparam int NV = 12;
   localparam vec_t VECS [NV] = '{
      '{enc(0, 11'd10,   5'd0,  3'd7, 5'd5,  OPV), 64'd0,       1, 7'd5,  64'd10, 0, 7'd10}, // R4 R6
      '{enc(0, 11'd20,   5'd3,  3'd7, 5'd6,  OPV), 64'd7,       1, 7'd6,  64'd7,  0, 7'd7},  // R5
      '{enc(0, 11'd20,   5'd3,  3'd7, 5'd6,  OPV), 64'h8000_0000_0000_0000, 1, 7'd6, 64'd20, 0, 7'd20}, // R5 unsigned
      '{enc(0, 11'd64,   5'd0,  3'd7, 5'd31, OPV), 64'd0,       1, 7'd31, 64'd64, 0, 7'd64}, // R3 boundary
      '{enc(0, 11'd65,   5'd0,  3'd7, 5'd1,  OPV), 64'd0,       0, 7'd1,  64'd0,  1, 7'd64}, // R3
      '{enc(1, 11'd5,    5'd0,  3'd7, 5'd1,  OPV), 64'd0,       0, 7'd1,  64'd0,  1, 7'd64}, // R2
      '{enc(0, 11'd9,    5'd0,  3'd7, 5'd0,  OPV), 64'd0,       0, 7'd0,  64'd0,  0, 7'd9},  // R6 rd zero
      '{enc(0, 11'd30,   5'd0,  3'd6, 5'd2,  OPV), 64'd0,       0, 7'd2,  64'd0,  0, 7'd9},  // R1 fn
      '{enc(0, 11'd30,   5'd0,  3'd7, 5'd2,  OPX), 64'd0,       0, 7'd2,  64'd0,  0, 7'd9},  // R1 op
      '{enc(0, 11'd0,    5'd4,  3'd7, 5'd3,  OPV), 64'd100,     1, 7'd3,  64'd0,  0, 7'd0},  // R5 zero max
      '{enc(0, 11'd2047, 5'd0,  3'd7, 5'd3,  OPV), 64'd0,       0, 7'd3,  64'd0,  1, 7'd0},  // R3 top
      '{enc(0, 11'd40,   5'd31, 3'd7, 5'd17, OPV), 64'd40,      1, 7'd17, 64'd40, 0, 7'd40}  // R5 equal R7
   };

   logic        clk = 1'b0;
   logic        rst;
   logic        insn_valid;
   logic [31:0] insn_word;
   logic [6:0]  src_idx;
   logic [63:0] src_data;
   logic        wr_en;
   logic [6:0]  wr_idx;
   logic [63:0] wr_data;
   logic        trap_pulse;
   logic [6:0]  cur_vl;

   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   vlcfg_unit u0 (
      .clk(clk), .rst(rst), .insn_valid(insn_valid), .insn_word(insn_word),
      .src_idx(src_idx), .src_data(src_data), .wr_en(wr_en), .wr_idx(wr_idx),
      .wr_data(wr_data), .trap_pulse(trap_pulse), .cur_vl(cur_vl)
   );

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   initial begin
      #(CLK_PERIOD * 5000);
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      rst = 1'b1; insn_valid = 1'b0; insn_word = '0; src_data = '0;
      repeat (2) @(negedge clk);
      rst = 1'b0;
      #1;
      chk("R8 reset vl", 64'(cur_vl), 64'd0);
      chk("R1 reset quiet", {62'd0, wr_en, trap_pulse}, 64'd0);

      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         insn_valid = 1'b1;
         insn_word  = VECS[i].insn;
         src_data   = VECS[i].src;
         #1;
         chk("R10 R1 wr_en", 64'(wr_en), 64'(VECS[i].we));
         chk("R9 R2 R3 trap", 64'(trap_pulse), 64'(VECS[i].trap));
         chk("R7 src_idx", 64'(src_idx), 64'({2'b00, VECS[i].insn[19:15]}));
         chk("R7 wr_idx", 64'(wr_idx), 64'(VECS[i].widx));
         if (VECS[i].we) chk("R4 R5 R6 wr_data", wr_data, VECS[i].wdata);
         @(negedge clk);
         insn_valid = 1'b0;
         #1;
         chk("R8 vl after edge", 64'(cur_vl), 64'(VECS[i].vl));
         chk("R9 trap drops", 64'(trap_pulse), 64'd0);
      end

      // R1: a legal word without the strobe changes nothing
      @(negedge clk);
      insn_word = enc(0, 11'd3, 5'd0, 3'd7, 5'd8, OPV);
      #1;
      chk("R1 no strobe write", 64'(wr_en), 64'd0);
      @(negedge clk);
      #1;
      chk("R1 no strobe vl", 64'(cur_vl), 64'd40);

      // R8: reset wins over a legal instruction in the same cycle
      @(negedge clk);
      rst = 1'b1; insn_valid = 1'b1;
      insn_word = enc(0, 11'd12, 5'd0, 3'd7, 5'd0, OPV);
      @(negedge clk);
      rst = 1'b0; insn_valid = 1'b0;
      #1;
      chk("R8 reset priority", 64'(cur_vl), 64'd0);

      // R6: rd zero with register operand still updates vl
      @(negedge clk);
      insn_valid = 1'b1;
      insn_word = enc(0, 11'd50, 5'd9, 3'd7, 5'd0, OPV);
      src_data = 64'd33;
      #1;
      chk("R6 rd zero no write", 64'(wr_en), 64'd0);
      @(negedge clk);
      insn_valid = 1'b0;
      #1;
      chk("R6 R5 vl update", 64'(cur_vl), 64'd33);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule